// File: doc/BRIEF.md
# CEC Frame Receive Controller

This block sits behind the bit-timing stage of a single-wire consumer-electronics control bus receiver. It takes one strobe per decoded bit and groups the bits into ten-bit blocks: eight data bits, sent most significant bit first, then an end-of-message bit, then an acknowledge slot. The first block of every frame is the header. Its low nibble is the destination address, and the block compares that address with a programmed logical address. From this it decides whether the frame is taken in and whether a logical 0 acknowledge is requested on the bus.

Accepted bytes are presented with a one-cycle strobe and an end-of-message flag. A frame that is complete raises an end interrupt. Errors from the bit-timing stage either abort the frame at once, or, in error-hold mode, are held back. In that mode the acknowledge of the failing block is inverted and a single error interrupt is raised after the acknowledge slot. Only in error-hold mode, a block whose bits stop arriving is closed by a programmable inactivity timeout. Software changes the configuration only while the enable is low, and it can see from the idle output that no frame is in progress.

Top module: `cec_rx`

## Requirements
- R1: While `enable` is low, bit strobes are ignored, `idle` is 1, and `ackDrive`, `rxStrobe`, `intEnd`, `intErr` and `intTimeout` are 0 from the next cycle on.
- R2: A block is 10 bit strobes: 8 data bits MSB first, then the end-of-message bit, then the acknowledge bit. For an accepted block, `rxStrobe` pulses for one cycle after the acknowledge bit, together with the byte on `rxByte` and the end-of-message bit on `rxEom`.
- R3: In a header block, `ackDrive` is 1 from the cycle after the 9th bit until the cycle after the 10th bit exactly when header bits [3:0] equal `myAddr`. `ackDataEn` has no effect on this.
- R4: In a data block, `ackDrive` is 1 in the same window only if the frame's header matched `myAddr` and `ackDataEn` is 1.
- R5: A header with destination 4'hF (broadcast) is always accepted and delivered, even when `recvOthers` is 0. It is not acknowledged unless `myAddr` is 4'hF.
- R6: A frame whose destination is neither `myAddr` nor 4'hF is delivered when `recvOthers` is 1. When `recvOthers` is 0 it gives no strobe, no acknowledge and no end interrupt.
- R7: `intEnd` pulses together with `rxStrobe` when an accepted block's end-of-message bit is 1. The next block is then treated as a header.
- R8: With `errHold` 0, any nonzero `errFlags` raises `intErr` in the next cycle, aborts the frame and returns the block to idle.
- R9: With `errHold` 1, a nonzero `errFlags` raises no interrupt at once. The block's acknowledge request is inverted. One `intErr` pulse follows the acknowledge bit, the byte is not delivered, and the block returns to idle.
- R10: With `errHold` 1 and a block partly received, `intTimeout` pulses once when N×BIT_CYCLES cycles pass with no bit strobe, counted from the last strobe. N is `toutSel`, and 0 counts as 1. The block then returns to idle. With `errHold` 0 no timeout is raised.
- R11: If a byte is delivered while the previous one has not yet been acknowledged on `byteRead`, `intErr` pulses with that `rxStrobe` (overrun).
- R12: `idle` is 1 exactly when no block is partly received and the next block is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Reception enable; low clears all frame state |
| bitValid | input | 1 | One-cycle strobe for a decoded bit |
| bitValue | input | 1 | Value of the decoded bit |
| errFlags | input | ERR_W | Error pulses from the bit-timing stage |
| myAddr | input | ADDR_W | Programmed logical address |
| ackDataEn | input | 1 | Acknowledge matching data blocks |
| recvOthers | input | 1 | Accept frames for other destinations |
| errHold | input | 1 | Hold error interrupts until the acknowledge or a timeout |
| toutSel | input | 2 | Timeout length in bit periods (0 counts as 1) |
| byteRead | input | 1 | Software has read `rxByte` |
| ackDrive | output | 1 | Request to pull the bus low in the acknowledge slot |
| rxByte | output | BYTE_W | Last delivered byte |
| rxEom | output | 1 | End-of-message bit of the delivered byte |
| rxStrobe | output | 1 | Byte delivered |
| intEnd | output | 1 | Accepted frame complete |
| intErr | output | 1 | Error interrupt |
| intTimeout | output | 1 | Inactivity timeout interrupt |
| idle | output | 1 | No frame in progress |

## Verification
On every cycle the assertions check the following: outputs stay quiet while disabled, the immediate error pulse when errors are not held, the absence of an early pulse when they are held, no timeout without error-hold, no acknowledge request while idle, and that an end interrupt comes only with a delivered byte. The bench scenarios are needed for the rest. These cover the acknowledge decision for headers and data blocks, broadcast and other-address acceptance, inverted acknowledges after held errors, the exact cycle a timeout fires for each length setting, and overrun on an unread byte.

// File: rtl/cec_rx_pkg.sv
`timescale 1ns/1ps
package cec_rx_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftEn;     // capture a data bit
    logic hdrBlk;      // current block is a header
    logic latchHdr;    // store header match/accept result
    logic loadByte;    // deliver shift register to rxByte
    logic clearFrame;  // forget frame match/accept
  } dpCtrl_t;
endpackage

// File: rtl/cec_rx_datapath.sv
`timescale 1ns/1ps
module cec_rx_datapath
  import cec_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitValue,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic              recvOthers,
  input  logic              ackDataEn,
  input  logic              byteRead,
  output logic              ackWanted,
  output logic              hdrAccept,
  output logic              frameAccept,
  output logic              unread,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] shiftReg;
  logic [ADDR_W-1:0] dest;
  logic              destHit, destBcast, frameHit;

  assign dest      = shiftReg[ADDR_W-1:0];
  assign destHit   = (dest == myAddr);
  assign destBcast = &dest;
  assign hdrAccept = destHit | destBcast | recvOthers;
  assign ackWanted = ctl.hdrBlk ? destHit : (frameHit & ackDataEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      rxByte      <= '0;
      frameHit    <= 1'b0;
      frameAccept <= 1'b0;
      unread      <= 1'b0;
    end else if (!enable) begin
      shiftReg    <= '0;
      frameHit    <= 1'b0;
      frameAccept <= 1'b0;
      unread      <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], bitValue};
      if (ctl.clearFrame) begin
        frameHit    <= 1'b0;
        frameAccept <= 1'b0;
      end else if (ctl.latchHdr) begin
        frameHit    <= destHit;
        frameAccept <= hdrAccept;
      end
      if (ctl.loadByte) begin
        rxByte <= shiftReg;
        unread <= 1'b1;
      end else if (byteRead) begin
        unread <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cec_rx_ctrl.sv
`timescale 1ns/1ps
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ERR_W      = 2,
  parameter int BIT_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             bitValid,
  input  logic             bitValue,
  input  logic [ERR_W-1:0] errFlags,
  input  logic             errHold,
  input  logic [1:0]       toutSel,
  input  logic             ackWanted,
  input  logic             hdrAccept,
  input  logic             frameAccept,
  input  logic             unread,
  output dpCtrl_t          ctl,
  output logic             ackDrive,
  output logic             rxStrobe,
  output logic             rxEom,
  output logic             intEnd,
  output logic             intErr,
  output logic             intTimeout,
  output logic             idle
);
  localparam int BLK_LEN = BYTE_W + 2;
  localparam int CNT_W   = $clog2(BLK_LEN);
  localparam int TW      = $clog2(3 * BIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] EOM_IDX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] bitCnt;
  logic [TW-1:0]    toutCnt, toutLimit;
  logic [1:0]       toutEff;
  logic expectHdr, errPending, eomReg;
  logic errNow, abortErr, holdFail, atData, atEom, atAck, accNow, busy, toutHit, deliver;

  assign errNow   = |errFlags;
  assign abortErr = errNow & ~errHold;
  assign holdFail = errHold & (errPending | errNow);
  assign atData   = bitValid & (bitCnt < EOM_IDX);
  assign atEom    = bitValid & (bitCnt == EOM_IDX);
  assign atAck    = bitValid & (bitCnt == ACK_IDX);
  assign accNow   = expectHdr ? hdrAccept : frameAccept;
  assign busy     = (bitCnt != '0);
  assign toutEff  = (toutSel == 2'd0) ? 2'd1 : toutSel;
  assign toutLimit = TW'(32'(toutEff) * BIT_CYCLES);
  assign toutHit  = errHold & busy & ~bitValid & (toutCnt == toutLimit - TW'(1));
  assign deliver  = atAck & accNow & ~holdFail & ~abortErr;
  assign idle     = expectHdr & ~busy;

  always_comb begin
    ctl            = '0;
    ctl.hdrBlk     = expectHdr;
    ctl.shiftEn    = enable & atData & ~abortErr;
    ctl.latchHdr   = enable & atAck & expectHdr & ~abortErr;
    ctl.loadByte   = enable & deliver;
    ctl.clearFrame = enable & (abortErr | toutHit | (atAck & (holdFail | eomReg)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; toutCnt <= '0; expectHdr <= 1'b1; errPending <= 1'b0; eomReg <= 1'b0;
      ackDrive <= 1'b0; rxStrobe <= 1'b0; rxEom <= 1'b0;
      intEnd <= 1'b0; intErr <= 1'b0; intTimeout <= 1'b0;
    end else if (!enable) begin
      bitCnt <= '0; toutCnt <= '0; expectHdr <= 1'b1; errPending <= 1'b0; eomReg <= 1'b0;
      ackDrive <= 1'b0; rxStrobe <= 1'b0;
      intEnd <= 1'b0; intErr <= 1'b0; intTimeout <= 1'b0;
    end else begin
      rxStrobe <= 1'b0; intEnd <= 1'b0; intErr <= 1'b0; intTimeout <= 1'b0;
      if (abortErr || toutHit) begin
        intErr     <= abortErr;
        intTimeout <= ~abortErr;
        bitCnt     <= '0;
        toutCnt    <= '0;
        expectHdr  <= 1'b1;
        errPending <= 1'b0;
        ackDrive   <= 1'b0;
      end else begin
        if (errHold && errNow) errPending <= 1'b1;
        if (bitValid) begin
          toutCnt <= '0;
          bitCnt  <= atAck ? '0 : bitCnt + CNT_W'(1);
          if (atEom) begin
            eomReg   <= bitValue;
            ackDrive <= ackWanted ^ holdFail;
          end
          if (atAck) begin
            ackDrive   <= 1'b0;
            errPending <= 1'b0;
            if (holdFail) begin
              intErr    <= 1'b1;
              expectHdr <= 1'b1;
            end else begin
              expectHdr <= eomReg;
              if (accNow) begin
                rxStrobe <= 1'b1;
                rxEom    <= eomReg;
                intEnd   <= eomReg;
                intErr   <= unread;
              end
            end
          end
        end else if (busy && errHold) begin
          toutCnt <= toutCnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cec_rx.sv
`timescale 1ns/1ps
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int ERR_W      = 2,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bitValid,
  input  logic              bitValue,
  input  logic [ERR_W-1:0]  errFlags,
  input  logic [ADDR_W-1:0] myAddr,
  input  logic              ackDataEn,
  input  logic              recvOthers,
  input  logic              errHold,
  input  logic [1:0]        toutSel,
  input  logic              byteRead,
  output logic              ackDrive,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxEom,
  output logic              rxStrobe,
  output logic              intEnd,
  output logic              intErr,
  output logic              intTimeout,
  output logic              idle
);
  dpCtrl_t ctl;
  logic ackWanted, hdrAccept, frameAccept, unread;

  cec_rx_ctrl #(.BYTE_W(BYTE_W), .ERR_W(ERR_W), .BIT_CYCLES(BIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid), .bitValue(bitValue),
    .errFlags(errFlags), .errHold(errHold), .toutSel(toutSel),
    .ackWanted(ackWanted), .hdrAccept(hdrAccept), .frameAccept(frameAccept), .unread(unread),
    .ctl(ctl), .ackDrive(ackDrive), .rxStrobe(rxStrobe), .rxEom(rxEom),
    .intEnd(intEnd), .intErr(intErr), .intTimeout(intTimeout), .idle(idle)
  );

  cec_rx_datapath #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValue(bitValue), .ctl(ctl),
    .myAddr(myAddr), .recvOthers(recvOthers), .ackDataEn(ackDataEn), .byteRead(byteRead),
    .ackWanted(ackWanted), .hdrAccept(hdrAccept), .frameAccept(frameAccept),
    .unread(unread), .rxByte(rxByte)
  );
endmodule

// File: rtl/cec_rx_checker.sv
`timescale 1ns/1ps
module cec_rx_checker #(
  parameter int ERR_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             bitValid,
  input logic [ERR_W-1:0] errFlags,
  input logic             errHold,
  input logic             ackDrive,
  input logic             rxStrobe,
  input logic             intEnd,
  input logic             intErr,
  input logic             intTimeout,
  input logic             idle
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!ackDrive && !rxStrobe && !intEnd && !intErr && !intTimeout && idle));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe);

  a_r7_end_with_byte: assert property (@(posedge clk) disable iff (!rstN)
    intEnd |-> rxStrobe);

  a_r8_err_at_once: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !errHold && (errFlags != '0)) |=> (intErr && idle && !ackDrive));

  a_r9_err_postponed: assert property (@(posedge clk) disable iff (!rstN)
    (enable && errHold && (errFlags != '0) && !bitValid) |=> !intErr);

  a_r10_no_tout_unheld: assert property (@(posedge clk) disable iff (!rstN)
    !errHold |=> !intTimeout);

  a_r12_idle_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !ackDrive);
endmodule

bind cec_rx cec_rx_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid), .errFlags(errFlags),
  .errHold(errHold), .ackDrive(ackDrive), .rxStrobe(rxStrobe), .intEnd(intEnd),
  .intErr(intErr), .intTimeout(intTimeout), .idle(idle)
);

// File: tb/tb_cec_rx.sv
`timescale 1ns/1ps
module tb_cec_rx;
  localparam int BITC = 16;
  localparam int GAP  = 3;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, bitValid = 1'b0, bitValue = 1'b0;
  logic [1:0] errFlags = '0, toutSel = 2'd1;
  logic [3:0] myAddr = 4'h4;
  logic ackDataEn = 1'b1, recvOthers = 1'b0, errHold = 1'b0, byteRead = 1'b0;
  logic ackDrive, rxEom, rxStrobe, intEnd, intErr, intTimeout, idle;
  logic [7:0] rxByte;

  int total = 0, bad = 0;
  logic sStrobe, sEnd, sErr, sTout, sEom;
  logic [7:0] sByte;

  cec_rx #(.BIT_CYCLES(BITC)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid), .bitValue(bitValue),
    .errFlags(errFlags), .myAddr(myAddr), .ackDataEn(ackDataEn), .recvOthers(recvOthers),
    .errHold(errHold), .toutSel(toutSel), .byteRead(byteRead), .ackDrive(ackDrive),
    .rxByte(rxByte), .rxEom(rxEom), .rxStrobe(rxStrobe), .intEnd(intEnd), .intErr(intErr),
    .intTimeout(intTimeout), .idle(idle)
  );

  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic expAck(input logic hdr, input logic hit, input logic dataEn, input logic err);
    return (hdr ? hit : (hit & dataEn)) ^ err;
  endfunction

  task automatic sendBit(input logic v);
    @(negedge clk); bitValid = 1'b1; bitValue = v;
    @(negedge clk); bitValid = 1'b0;
    sStrobe = rxStrobe; sEnd = intEnd; sErr = intErr; sTout = intTimeout;
    sByte = rxByte; sEom = rxEom;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic injectErr();
    @(negedge clk); errFlags = 2'b01;
    @(negedge clk); errFlags = 2'b00; sErr = intErr;
  endtask

  task automatic pulseRead();
    @(negedge clk); byteRead = 1'b1;
    @(negedge clk); byteRead = 1'b0;
  endtask

  // sends one block; errAt < 0 means no error injection
  task automatic sendBlock(input logic [7:0] b, input logic eom, input int errAt,
                           input string tag, output logic ackSeen);
    for (int i = 0; i < 8; i++) begin
      sendBit(b[7-i]);
      if (i == errAt) begin
        injectErr();
        chk({tag, " R9 no early intErr"}, sErr, 1'b0);
      end
    end
    sendBit(eom);
    ackSeen = ackDrive;
    sendBit(1'b1);
  endtask

  task automatic runFrame(input logic [7:0] hdr, input int nData, input int errBlk, input int errBit);
    logic hit, bc, acc, ackSeen, e, eom;
    logic [7:0] b;
    string tag;
    hit = (hdr[3:0] == myAddr);
    bc  = (hdr[3:0] == 4'hF);
    acc = hit | bc | recvOthers;
    tag = (bc && !hit) ? "R5" : (!hit ? "R6" : "R2");
    for (int blk = 0; blk <= nData; blk++) begin
      b   = (blk == 0) ? hdr : 8'($urandom);
      eom = (blk == nData);
      e   = (blk == errBlk) && errHold;
      sendBlock(b, eom, e ? errBit : -1, tag, ackSeen);
      chk(blk == 0 ? "R3 header ack" : "R4 data ack", ackSeen,
          expAck(blk == 0, hit, ackDataEn, e));
      chk({tag, " strobe"}, sStrobe, acc && !e);
      if (acc && !e) begin
        chk("R2 byte", sByte, b);
        chk("R2 eom", sEom, eom);
      end
      chk("R7 end", sEnd, acc && !e && eom);
      chk(e ? "R9 held err" : "R11 no overrun", sErr, e);
      if (sStrobe) pulseRead();
      if (e) break;
    end
    chk("R12 idle after frame", idle, 1'b1);
  endtask

  initial begin
    logic ackSeen;
    int k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset idle", idle, 1'b1);
    chk("R1 reset outputs", {ackDrive, rxStrobe, intEnd, intErr, intTimeout}, 5'b0);
    rstN = 1'b1;

    // R1: disabled, bits ignored
    sendBlock(8'h44, 1'b1, -1, "R1", ackSeen);
    chk("R1 no ack off", ackSeen, 1'b0);
    chk("R1 no strobe off", sStrobe, 1'b0);
    chk("R1 idle off", idle, 1'b1);

    // directed: matching header, ack-disable on data
    enable = 1'b1; myAddr = 4'h4; ackDataEn = 1'b0; recvOthers = 1'b0;
    runFrame(8'h04, 2, -1, 0);
    // R12 mid-frame not idle
    sendBlock(8'h34, 1'b0, -1, "R12", ackSeen);
    chk("R12 not idle between blocks", idle, 1'b0);
    pulseRead();
    sendBlock(8'h99, 1'b1, -1, "R12", ackSeen);
    pulseRead();
    chk("R12 idle at end", idle, 1'b1);

    // broadcast with others disabled, non-matching frame dropped
    runFrame(8'h3F, 1, -1, 0);
    runFrame(8'h37, 1, -1, 0);
    recvOthers = 1'b1;
    runFrame(8'h37, 1, -1, 0);
    recvOthers = 1'b0; ackDataEn = 1'b1;

    // R11 overrun: no read between blocks
    sendBlock(8'h14, 1'b0, -1, "R11", ackSeen);
    sendBlock(8'h55, 1'b1, -1, "R11", ackSeen);
    chk("R11 strobe", sStrobe, 1'b1);
    chk("R11 overrun err", sErr, 1'b1);
    chk("R11 byte", sByte, 8'h55);
    pulseRead();

    // R8 immediate error abort
    errHold = 1'b0;
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    injectErr();
    chk("R8 immediate intErr", sErr, 1'b1);
    chk("R8 idle after abort", idle, 1'b1);
    runFrame(8'h04, 1, -1, 0);

    // R9 held error, inverted ack in header and data blocks
    errHold = 1'b1; toutSel = 2'd3;
    runFrame(8'h04, 2, 0, 3);
    runFrame(8'h04, 2, 1, 5);
    runFrame(8'h0F, 1, 1, 0);

    // R10 timeouts for several lengths
    for (int s = 0; s < 4; s++) begin
      toutSel = 2'(s);
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
      k = GAP;
      while (k < 100) begin
        @(negedge clk); k++;
        if (intTimeout) break;
      end
      chk("R10 timeout cycle", k, (s == 0 ? 1 : s) * BITC);
      @(negedge clk);
      chk("R10 single pulse", intTimeout, 1'b0);
      chk("R10 idle after timeout", idle, 1'b1);
    end
    // R10 no timeout without hold
    errHold = 1'b0; toutSel = 2'd1;
    sendBit(1'b1); sendBit(1'b1);
    k = 0;
    repeat (4 * BITC) begin
      @(negedge clk);
      if (intTimeout) k++;
    end
    chk("R10 no timeout unheld", k, 0);
    chk("R12 stuck block not idle", idle, 1'b0);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); chk("R1 disable clears", idle, 1'b1);
    enable = 1'b1;

    // constrained random frames
    for (int f = 0; f < 40; f++) begin
      logic [7:0] h;
      int eb;
      myAddr = 4'($urandom_range(0, 15));
      ackDataEn = 1'($urandom);
      recvOthers = 1'($urandom);
      errHold = 1'($urandom);
      toutSel = 2'd3;
      h = 8'($urandom);
      if ($urandom_range(0, 2) == 0) h[3:0] = myAddr;
      eb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2)) : -1;
      runFrame(h, int'($urandom_range(0, 3)), eb, int'($urandom_range(0, 7)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule